// File: doc/BRIEF.md
# Register result status rename table

This block holds the architectural integer register file together with a per-register producer field. The field names the reservation station that will write the register next, or reads blank (zero) when no in-flight instruction targets it. An issue stage presents two source indices and one destination index in a cycle. For each source the block returns either a ready value or the tag of the pending producer. On the next clock edge it records the issuing station's tag against the destination.

The block also watches the result broadcast bus. A broadcast writes its data into a register only when its tag equals the tag recorded for that register, and then clears the field. When several in-flight instructions target the same register, only the newest one is allowed to land. This removes write-after-read and write-after-write hazards without stalling. A flush input drops every pending claim and leaves the stored values untouched.

Top module: `reg_status_table`

## Requirements
- R1: The table holds 32 registers of 32 bits. After reset every register reads value 0 with a blank (0) producer tag.
- R2: Source index 0 always returns value 0 and tag 0. An issue whose destination is index 0 records nothing.
- R3: A source whose producer field is blank returns its stored value, with tag 0.
- R4: A source whose producer field holds a nonzero tag returns that tag, with value 0.
- R5: An issue (valid high, destination nonzero, no flush) sets the destination's producer field to the issue tag on the clock edge. This replaces any earlier tag, so the last writer wins.
- R6: A broadcast with a nonzero tag writes its data into every register whose producer field equals that tag, and blanks those fields. Registers holding any other tag, including a register re-claimed by a later issue, keep both value and tag.
- R7: In the same cycle as a broadcast whose tag matches a source's producer field, the source returns the broadcast data with tag 0.
- R8: If an issue claims a register in the same cycle that a broadcast matches it, the new tag is kept. The broadcast data is still written into the register value, and becomes visible once the claim is flushed.
- R9: A flush blanks every producer field on the clock edge and leaves the register values unchanged. An issue or broadcast presented in a flush cycle has no effect on the state.
- R10: Source lookups see the state from before the current cycle's issue. A source equal to the destination of the same issue returns the older value or tag.
- R11: A broadcast carrying tag 0 changes no register and forwards nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Blank every producer field |
| iss_valid | input | 1 | Issue present this cycle |
| iss_src_a | input | 5 | First source register index |
| iss_src_b | input | 5 | Second source register index |
| iss_dst | input | 5 | Destination register index |
| iss_tag | input | 4 | Tag of the issuing station (nonzero) |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | 4 | Tag of the broadcasting station |
| bc_data | input | 32 | Broadcast result value |
| a_val | output | 32 | First source value (0 when a tag is returned) |
| a_tag | output | 4 | First source producer tag (0 when the value is ready) |
| b_val | output | 32 | Second source value (0 when a tag is returned) |
| b_tag | output | 4 | Second source producer tag (0 when the value is ready) |

## Verification
A wrong producer field shows at a source port in the first cycle that the register is looked up. It appears either as a stale tag where a value is expected, or as a ready value while a producer is still pending. A tag-gating error shows at once as a wrong value when a stale broadcast lands on a re-claimed register. A value lost under a pending tag surfaces only when the tag clears or a flush exposes it. For that reason the sweep reads both ports every cycle and flushes periodically, so hidden values are exposed within a few cycles.

// File: rtl/reg_status_table.sv
module reg_status_table #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int TW   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    iss_valid,
  input  logic [$clog2(NREG)-1:0] iss_src_a,
  input  logic [$clog2(NREG)-1:0] iss_src_b,
  input  logic [$clog2(NREG)-1:0] iss_dst,
  input  logic [TW-1:0]           iss_tag,
  input  logic                    bc_valid,
  input  logic [TW-1:0]           bc_tag,
  input  logic [DW-1:0]           bc_data,
  output logic [DW-1:0]           a_val,
  output logic [TW-1:0]           a_tag,
  output logic [DW-1:0]           b_val,
  output logic [TW-1:0]           b_tag
);
  localparam int AW = $clog2(NREG);

  logic [DW-1:0] rf [NREG];
  logic [TW-1:0] st [NREG];
  logic          bc_hit;
  logic          pend_any;

  assign bc_hit = bc_valid && (bc_tag != '0);

  generate
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      if (r == 0) begin : g_zero
        assign rf[r] = '0;
        assign st[r] = '0;
      end else begin : g_live
        logic match, claim;
        assign match = bc_hit && (st[r] == bc_tag);
        assign claim = iss_valid && (iss_dst == AW'(r));
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            rf[r] <= '0;
            st[r] <= '0;
          end else if (flush) begin
            st[r] <= '0;
          end else begin
            if (match) rf[r] <= bc_data;
            if (claim) st[r] <= iss_tag;
            else if (match) st[r] <= '0;
          end
        end
      end
    end
  endgenerate

  function automatic logic [DW+TW-1:0] lookup(input logic [AW-1:0] s);
    logic [TW-1:0] t;
    t = st[s];
    if (t == '0)                     return {rf[s], {TW{1'b0}}};
    else if (bc_hit && bc_tag == t)  return {bc_data, {TW{1'b0}}};
    else                             return {{DW{1'b0}}, t};
  endfunction

  assign {a_val, a_tag} = lookup(iss_src_a);
  assign {b_val, b_tag} = lookup(iss_src_b);

  always_comb begin
    pend_any = 1'b0;
    for (int i = 0; i < NREG; i++) pend_any = pend_any | (st[i] != '0);
  end

  assert_zero_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_src_a == '0) |-> (a_val == '0 && a_tag == '0));

  assert_tag_hides_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (b_tag != '0) |-> (b_val == '0));

  assert_claim_recorded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !flush && iss_dst != '0) |=> (st[$past(iss_dst)] == $past(iss_tag)));

  assert_flush_blanks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !pend_any);

  assert_tag0_inert_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && bc_tag == '0 && !iss_valid && !flush) |=> $stable(pend_any));
endmodule

// File: tb/tb_reg_status_table.sv
module tb_reg_status_table;
  logic        clk = 0, rst_n = 0, flush = 0, iss_valid = 0, bc_valid = 0;
  logic [4:0]  iss_src_a = 0, iss_src_b = 0, iss_dst = 0;
  logic [3:0]  iss_tag = 0, bc_tag = 0;
  logic [31:0] bc_data = 0;
  logic [31:0] a_val, b_val;
  logic [3:0]  a_tag, b_tag;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] m_rf [32];
  logic [3:0]  m_st [32];

  always #2 clk = ~clk;

  reg_status_table dut (.*);

  function automatic logic [35:0] expect_src(input logic [4:0] s);
    if (s == 0) return '0;
    if (m_st[s] == 0) return {m_rf[s], 4'd0};
    if (bc_valid && bc_tag != 0 && bc_tag == m_st[s]) return {bc_data, 4'd0};
    return {32'd0, m_st[s]};
  endfunction

  task automatic chk(input string req, input string what, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual val=%h tag=%0d expected val=%h tag=%0d",
               req, what, act[35:4], act[3:0], exp[35:4], exp[3:0]);
    end
  endtask

  task automatic cyc(input string req, input bit fl, input bit iv, input logic [4:0] sa,
                     input logic [4:0] sb, input logic [4:0] d, input logic [3:0] t,
                     input bit bv, input logic [3:0] bt, input logic [31:0] bd);
    @(negedge clk);
    flush = fl; iss_valid = iv; iss_src_a = sa; iss_src_b = sb; iss_dst = d; iss_tag = t;
    bc_valid = bv; bc_tag = bt; bc_data = bd;
    #1;
    chk(req, "port a", {a_val, a_tag}, expect_src(sa));
    chk(req, "port b", {b_val, b_tag}, expect_src(sb));
    @(posedge clk);
    if (fl) begin
      for (int r = 0; r < 32; r++) m_st[r] = 0;
    end else begin
      for (int r = 1; r < 32; r++) begin
        bit hit;
        hit = bv && bt != 0 && m_st[r] == bt;
        if (hit) m_rf[r] = bd;
        if (iv && d == r) m_st[r] = t;
        else if (hit) m_st[r] = 0;
      end
    end
  endtask

  task automatic rd(input string req, input logic [4:0] sa, input logic [4:0] sb);
    cyc(req, 0, 0, sa, sb, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int r = 0; r < 32; r++) begin m_rf[r] = 0; m_st[r] = 0; end
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1: reset state over every register
    for (int r = 0; r < 32; r++) rd("R1", 5'(r), 5'(31 - r));
    // R3: write values via issue then broadcast
    for (int r = 1; r < 8; r++) begin
      cyc("R5", 0, 1, 5'(r), 0, 5'(r), 4'(r), 0, 0, 0);
      cyc("R6", 0, 0, 0, 0, 0, 0, 1, 4'(r), 32'h1000 + r);
    end
    for (int r = 1; r < 8; r++) rd("R3", 5'(r), 5'(r + 1));
    // R4 and R5: pending tag, then replaced by later writer
    cyc("R5", 0, 1, 0, 0, 5, 3, 0, 0, 0);
    rd("R4", 5, 4);
    cyc("R5", 0, 1, 5, 0, 5, 7, 0, 0, 0);
    rd("R5", 5, 5);
    // R6: stale broadcast tag 3 must not land on r5
    cyc("R6", 0, 0, 5, 0, 0, 0, 1, 3, 32'hDEAD0003);
    rd("R6", 5, 0);
    // R7: forwarding of matching broadcast
    cyc("R7", 0, 0, 5, 6, 0, 0, 1, 7, 32'hCAFE0007);
    rd("R3", 5, 0);
    // R2: destination 0 and source 0
    cyc("R2", 0, 1, 0, 0, 0, 9, 0, 0, 0);
    cyc("R2", 0, 0, 0, 0, 0, 0, 1, 9, 32'h55);
    rd("R2", 0, 0);
    // R10: source equals same-cycle destination
    cyc("R10", 0, 1, 6, 6, 6, 4, 0, 0, 0);
    cyc("R10", 0, 1, 6, 6, 6, 5, 0, 0, 0);
    rd("R10", 6, 0);
    // R8: claim and matching broadcast together, flush exposes value
    cyc("R8", 0, 1, 0, 0, 6, 11, 1, 5, 32'hABCD0008);
    rd("R8", 6, 0);
    cyc("R9", 1, 1, 6, 0, 7, 12, 1, 11, 32'h0BAD);
    rd("R8", 6, 7);
    // R11: tag-0 broadcast
    cyc("R11", 0, 1, 0, 0, 2, 2, 0, 0, 0);
    cyc("R11", 0, 0, 2, 3, 0, 0, 1, 0, 32'h77777777);
    rd("R11", 2, 3);
    // R9: flush with pending claims keeps values
    cyc("R9", 1, 0, 2, 0, 0, 0, 0, 0, 0);
    rd("R9", 2, 1);
    // R6: tag shared by several registers
    cyc("R6", 0, 1, 0, 0, 9, 6, 0, 0, 0);
    cyc("R6", 0, 1, 0, 0, 10, 6, 0, 0, 0);
    cyc("R6", 0, 0, 9, 10, 0, 0, 1, 6, 32'h12345678);
    rd("R6", 9, 10);
    // sweep
    lf = 16'hACE1;
    for (int i = 0; i < 6000; i++) begin
      logic [4:0] sa, sb, d;
      logic [3:0] t, bt;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      sa = {2'b0, lf[2:0]} + (lf[15] ? 5'd8 : 5'd0);
      sb = lf[7:3];
      d  = {1'b0, lf[11:8]};
      t  = (lf[14:12] == 0) ? 4'd1 : {1'b0, lf[14:12]};
      bt = {1'b0, lf[5:3]};
      cyc("R6", (i % 97) == 96, lf[0], sa, sb, d, t, lf[1] | lf[9], bt, {lf, ~lf});
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule